// File: doc/BRIEF.md
# Temporal Region Compactor

This block compacts a stream of retired instruction addresses into spatial regions. A region is named by a trigger cache block. Two footprint vectors record which nearby blocks were touched: one for blocks below the trigger and one for blocks above it. The region currently being filled is the active region. Behind it sits a short list of recently active regions, held in recency order.

When an address falls outside the active region, the block searches that list. A matching region is swapped back in as the active region. An address that matches nowhere ends the active region. That region's trigger and both vectors go out on a one-cycle history write strobe, aimed at external history and index storage. A fresh active region then starts at the new address.

The active region is visible on its own outputs, so that a stream predictor can read it. All state is registered. An address presented in one cycle is reflected on the outputs, and on the history strobe, from the next clock edge.

Top module: `tcr_compactor`

## Requirements
- R1: After reset, `act_valid` and `hist_we` are 0.
- R2: The first valid address after reset makes its block (address bits above `LOG_BLK`) the active trigger, with both footprint vectors zero and no history write.
- R3: A valid address in the same block as the active trigger changes nothing.
- R4: A valid address whose block lies d blocks above the active trigger, with 1 ≤ d ≤ SUCC_N, sets bit d-1 of `act_succ`. Nothing else changes.
- R5: A valid address whose block lies d blocks below the active trigger, with 1 ≤ d ≤ PREC_N, sets bit d-1 of `act_prev`. Nothing else changes.
- R6: A valid address outside the active region that lies inside a listed region makes that region active again. Its stored vectors come back unchanged, the address does not set a bit in them, the old active region is placed at the most-recent end of the list, and no history write occurs.
- R7: A valid address outside the active region and outside every listed region raises `hist_we` for one cycle. The strobe carries the old active trigger and vectors. The old region joins the list at the most-recent end, and the active region restarts at the new block with zero vectors.
- R8: When the list already holds DEPTH regions on such a miss, its least-recent region is discarded. A later address in that region is a miss.
- R9: While `ret_valid` is 0, the active region, the list and the history strobe do not change, whatever `ret_addr` holds.
- R10: When several listed regions contain the address, the most recently inserted one becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A retired address is presented this cycle |
| ret_addr | input | ADDR_W | Retired instruction address |
| act_valid | output | 1 | An active region exists |
| act_trigger | output | ADDR_W-LOG_BLK | Block number of the active trigger |
| act_prev | output | PREC_N | Active footprint below the trigger, bit d-1 = distance d |
| act_succ | output | SUCC_N | Active footprint above the trigger, bit d-1 = distance d |
| hist_we | output | 1 | One-cycle history write strobe |
| hist_trigger | output | ADDR_W-LOG_BLK | Trigger block of the region written out |
| hist_prev | output | PREC_N | Lower footprint of the region written out |
| hist_succ | output | SUCC_N | Upper footprint of the region written out |

## Verification
Some rules are checked by assertions on every cycle. These are: an idle cycle and a same-block address leave the active region untouched; the first address starts clean; each history strobe follows a valid address, carries the previous active trigger and leaves cleared vectors behind. List behaviour cannot be seen by any single-cycle property, because it depends on the recency order built up over many earlier events. That covers swaps, the choice between overlapping listed regions, and the loss of the least-recent entry. Only the bench's behavioural model, run through directed sequences and a long random stream over a narrow address range, can show it.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

   // Classification of one retired address against the compactor state
   typedef enum logic [2:0] {
      EV_IDLE  = 3'd0,
      EV_FIRST = 3'd1,
      EV_LOCAL = 3'd2,
      EV_SWAP  = 3'd3,
      EV_MISS  = 3'd4
   } tcr_event_t;

   function automatic int unsigned tcr_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tcr_region_probe.sv
// Membership test of one block against one region; optional footprint bits.
module tcr_region_probe #(
   parameter int unsigned BLK_W  = 12,
   parameter int unsigned PREC_N = 3,
   parameter int unsigned SUCC_N = 5,
   parameter bit          TRACK  = 1'b1
) (
   input  logic              valid,
   input  logic [BLK_W-1:0]  trig,
   input  logic [BLK_W-1:0]  blk,
   output logic              hit,
   output logic [PREC_N-1:0] prev_set,
   output logic [SUCC_N-1:0] succ_set
);
   localparam logic [BLK_W-1:0] PREC_L = BLK_W'(PREC_N);
   localparam logic [BLK_W-1:0] SUCC_L = BLK_W'(SUCC_N);

   logic             above, below, same;
   logic [BLK_W-1:0] dist_up, dist_dn;
   logic             in_up, in_dn;

   always_comb begin
      above   = blk > trig;
      below   = blk < trig;
      same    = blk == trig;
      dist_up = blk - trig;
      dist_dn = trig - blk;
      in_up   = above && (dist_up <= SUCC_L);
      in_dn   = below && (dist_dn <= PREC_L);
      hit     = valid && (same || in_up || in_dn);
   end

   if (TRACK) begin : g_track
      for (genvar i = 0; i < int'(PREC_N); i++) begin : g_prev
         assign prev_set[i] = valid && in_dn && (dist_dn == BLK_W'(i + 1));
      end
      for (genvar j = 0; j < int'(SUCC_N); j++) begin : g_succ
         assign succ_set[j] = valid && in_up && (dist_up == BLK_W'(j + 1));
      end
   end else begin : g_no_track
      assign prev_set = '0;
      assign succ_set = '0;
   end

endmodule

// File: rtl/tcr_first_hit.sv
// Lowest-index request wins (index 0 is the most recent list entry).
module tcr_first_hit #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             req [N],
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tcr_recency_list.sv
// Shift-register list ordered by recency; entry 0 is the most recent.
// A shift moves entries 0..sel-1 down by one and loads entry 0,
// so entry sel is overwritten (taken out on a swap, dropped on a miss).
module tcr_recency_list #(
   parameter int unsigned BLK_W  = 12,
   parameter int unsigned PREC_N = 3,
   parameter int unsigned SUCC_N = 5,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [IDX_W-1:0]  sel,
   input  logic [BLK_W-1:0]  in_trig,
   input  logic [PREC_N-1:0] in_prev,
   input  logic [SUCC_N-1:0] in_succ,
   output logic              ent_valid [DEPTH],
   output logic [BLK_W-1:0]  ent_trig  [DEPTH],
   output logic [PREC_N-1:0] ent_prev  [DEPTH],
   output logic [SUCC_N-1:0] ent_succ  [DEPTH]
);
   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_ent
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_valid[i] <= 1'b0;
               ent_trig[i]  <= '0;
               ent_prev[i]  <= '0;
               ent_succ[i]  <= '0;
            end else if (shift_en) begin
               ent_valid[i] <= 1'b1;
               ent_trig[i]  <= in_trig;
               ent_prev[i]  <= in_prev;
               ent_succ[i]  <= in_succ;
            end
         end
      end else begin : g_body
         logic move;
         assign move = shift_en && (IDX_W'(i) <= sel);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_valid[i] <= 1'b0;
               ent_trig[i]  <= '0;
               ent_prev[i]  <= '0;
               ent_succ[i]  <= '0;
            end else if (move) begin
               ent_valid[i] <= ent_valid[i-1];
               ent_trig[i]  <= ent_trig[i-1];
               ent_prev[i]  <= ent_prev[i-1];
               ent_succ[i]  <= ent_succ[i-1];
            end
         end
      end
   end
endmodule

// File: rtl/tcr_compactor.sv
module tcr_compactor #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LOG_BLK = 4,
   parameter int unsigned PREC_N  = 3,
   parameter int unsigned SUCC_N  = 5,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ret_valid,
   input  logic [ADDR_W-1:0]         ret_addr,
   output logic                      act_valid,
   output logic [ADDR_W-LOG_BLK-1:0] act_trigger,
   output logic [PREC_N-1:0]         act_prev,
   output logic [SUCC_N-1:0]         act_succ,
   output logic                      hist_we,
   output logic [ADDR_W-LOG_BLK-1:0] hist_trigger,
   output logic [PREC_N-1:0]         hist_prev,
   output logic [SUCC_N-1:0]         hist_succ
);
   import tcr_pkg::*;

   localparam int unsigned BLK_W = ADDR_W - LOG_BLK;
   localparam int unsigned IDX_W = tcr_idx_width(DEPTH);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   // Elaboration-time parameter checks
   if (LOG_BLK >= ADDR_W) begin : g_bad_blk
      $error("tcr_compactor: LOG_BLK must be below ADDR_W");
   end
   if (PREC_N < 1 || SUCC_N < 1) begin : g_bad_vec
      $error("tcr_compactor: footprint vectors need at least one bit");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("tcr_compactor: list needs at least one entry");
   end
   if (BLK_W < 2 || (1 << BLK_W) <= (PREC_N + SUCC_N)) begin : g_bad_span
      $error("tcr_compactor: block number too narrow for region span");
   end

   logic [BLK_W-1:0] cur_blk;
   assign cur_blk = ret_addr[ADDR_W-1:LOG_BLK];

   // Active region state
   logic              a_valid_q;
   logic [BLK_W-1:0]  a_trig_q;
   logic [PREC_N-1:0] a_prev_q;
   logic [SUCC_N-1:0] a_succ_q;

   // Probe of the active region, with footprint tracking
   logic              a_hit;
   logic [PREC_N-1:0] a_prev_set;
   logic [SUCC_N-1:0] a_succ_set;

   tcr_region_probe #(
      .BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N), .TRACK(1'b1)
   ) u_act_probe (
      .valid    (a_valid_q),
      .trig     (a_trig_q),
      .blk      (cur_blk),
      .hit      (a_hit),
      .prev_set (a_prev_set),
      .succ_set (a_succ_set)
   );

   // Recency list
   logic              lst_shift;
   logic [IDX_W-1:0]  lst_sel;
   logic              e_valid [DEPTH];
   logic [BLK_W-1:0]  e_trig  [DEPTH];
   logic [PREC_N-1:0] e_prev  [DEPTH];
   logic [SUCC_N-1:0] e_succ  [DEPTH];

   tcr_recency_list #(
      .BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N),
      .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_list (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (lst_shift),
      .sel       (lst_sel),
      .in_trig   (a_trig_q),
      .in_prev   (a_prev_q),
      .in_succ   (a_succ_q),
      .ent_valid (e_valid),
      .ent_trig  (e_trig),
      .ent_prev  (e_prev),
      .ent_succ  (e_succ)
   );

   // Membership of each list entry; entries are never updated by a probe
   logic e_hit [DEPTH];

   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_lprobe
      logic [PREC_N-1:0] unused_prev;
      logic [SUCC_N-1:0] unused_succ;
      tcr_region_probe #(
         .BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N), .TRACK(1'b0)
      ) u_probe (
         .valid    (e_valid[i]),
         .trig     (e_trig[i]),
         .blk      (cur_blk),
         .hit      (e_hit[i]),
         .prev_set (unused_prev),
         .succ_set (unused_succ)
      );
   end

   logic             l_found;
   logic [IDX_W-1:0] l_idx;

   tcr_first_hit #(.N(DEPTH), .IDX_W(IDX_W)) u_first (
      .req   (e_hit),
      .found (l_found),
      .idx   (l_idx)
   );

   // Event classification
   tcr_event_t ev;

   always_comb begin
      if (!ret_valid)      ev = EV_IDLE;
      else if (!a_valid_q) ev = EV_FIRST;
      else if (a_hit)      ev = EV_LOCAL;
      else if (l_found)    ev = EV_SWAP;
      else                 ev = EV_MISS;
   end

   assign lst_shift = (ev == EV_SWAP) || (ev == EV_MISS);
   assign lst_sel   = (ev == EV_SWAP) ? l_idx : LAST_IDX;

   // Next active region
   logic [BLK_W-1:0]  n_trig;
   logic [PREC_N-1:0] n_prev;
   logic [SUCC_N-1:0] n_succ;

   always_comb begin
      n_trig = a_trig_q;
      n_prev = a_prev_q;
      n_succ = a_succ_q;
      unique case (ev)
         EV_FIRST, EV_MISS: begin
            n_trig = cur_blk;
            n_prev = '0;
            n_succ = '0;
         end
         EV_LOCAL: begin
            n_prev = a_prev_q | a_prev_set;
            n_succ = a_succ_q | a_succ_set;
         end
         EV_SWAP: begin
            n_trig = e_trig[l_idx];
            n_prev = e_prev[l_idx];
            n_succ = e_succ[l_idx];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid_q <= 1'b0;
         a_trig_q  <= '0;
         a_prev_q  <= '0;
         a_succ_q  <= '0;
      end else if (ev != EV_IDLE) begin
         a_valid_q <= 1'b1;
         a_trig_q  <= n_trig;
         a_prev_q  <= n_prev;
         a_succ_q  <= n_succ;
      end
   end

   // History write port: one strobe per region that missed everywhere
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_we      <= 1'b0;
         hist_trigger <= '0;
         hist_prev    <= '0;
         hist_succ    <= '0;
      end else begin
         hist_we <= (ev == EV_MISS);
         if (ev == EV_MISS) begin
            hist_trigger <= a_trig_q;
            hist_prev    <= a_prev_q;
            hist_succ    <= a_succ_q;
         end
      end
   end

   assign act_valid   = a_valid_q;
   assign act_trigger = a_trig_q;
   assign act_prev    = a_prev_q;
   assign act_succ    = a_succ_q;

endmodule

// File: rtl/tcr_compactor_chk.sv
module tcr_compactor_chk #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LOG_BLK = 4,
   parameter int unsigned PREC_N  = 3,
   parameter int unsigned SUCC_N  = 5,
   parameter int unsigned DEPTH   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ret_valid,
   input logic [ADDR_W-1:0]         ret_addr,
   input logic                      act_valid,
   input logic [ADDR_W-LOG_BLK-1:0] act_trigger,
   input logic [PREC_N-1:0]         act_prev,
   input logic [SUCC_N-1:0]         act_succ,
   input logic                      hist_we,
   input logic [ADDR_W-LOG_BLK-1:0] hist_trigger
);
   logic same_blk;
   assign same_blk = ret_addr[ADDR_W-1:LOG_BLK] == act_trigger;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !act_valid && !hist_we); // R1

   AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && !act_valid |=> act_valid && !hist_we
                                   && act_prev == '0 && act_succ == '0); // R2

   AST_SAME_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid && act_valid && same_blk |=>
         $stable(act_trigger) && $stable(act_prev) && $stable(act_succ)
         && !hist_we); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_valid |=> $stable(act_valid) && $stable(act_trigger)
         && $stable(act_prev) && $stable(act_succ) && !hist_we); // R9

   AST_HIST_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      hist_we |-> $past(ret_valid) && $past(act_valid)
                  && hist_trigger == $past(act_trigger)); // R7

   AST_HIST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      hist_we |-> act_prev == '0 && act_succ == '0
                  && act_trigger == $past(ret_addr[ADDR_W-1:LOG_BLK])); // R7

endmodule

bind tcr_compactor tcr_compactor_chk #(
   .ADDR_W(ADDR_W), .LOG_BLK(LOG_BLK), .PREC_N(PREC_N),
   .SUCC_N(SUCC_N), .DEPTH(DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ret_valid    (ret_valid),
   .ret_addr     (ret_addr),
   .act_valid    (act_valid),
   .act_trigger  (act_trigger),
   .act_prev     (act_prev),
   .act_succ     (act_succ),
   .hist_we      (hist_we),
   .hist_trigger (hist_trigger)
);

// File: tb/tcr_compactor_bench.sv
module tcr_compactor_bench;
   localparam int ADDR_W  = 16;
   localparam int LOG_BLK = 4;
   localparam int PREC_N  = 3;
   localparam int SUCC_N  = 5;
   localparam int DEPTH   = 4;
   localparam int BLK_W   = ADDR_W - LOG_BLK;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ret_valid = 1'b0;
   logic [ADDR_W-1:0] ret_addr = '0;
   logic              act_valid, hist_we;
   logic [BLK_W-1:0]  act_trigger, hist_trigger;
   logic [PREC_N-1:0] act_prev, hist_prev;
   logic [SUCC_N-1:0] act_succ, hist_succ;

   always #2.5 clk = ~clk;   // 200 MHz

   tcr_compactor #(
      .ADDR_W(ADDR_W), .LOG_BLK(LOG_BLK), .PREC_N(PREC_N),
      .SUCC_N(SUCC_N), .DEPTH(DEPTH)
   ) u_tcr_compactor (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
      .act_valid(act_valid), .act_trigger(act_trigger),
      .act_prev(act_prev), .act_succ(act_succ),
      .hist_we(hist_we), .hist_trigger(hist_trigger),
      .hist_prev(hist_prev), .hist_succ(hist_succ)
   );

   // Behavioural reference model
   typedef struct {
      int              trig;
      bit [PREC_N-1:0] pv;
      bit [SUCC_N-1:0] sv;
   } region_t;

   region_t   lst[$];
   region_t   m_act;
   bit        m_av;
   bit        m_hwe;
   region_t   m_hist;
   string     cur_req = "R1";
   string     exp_req = "R1";
   int        errors = 0;
   int        checks = 0;
   bit        checking = 1'b0;
   bit        done = 1'b0;

   function automatic bit contains(region_t r, int b);
      if (b == r.trig) return 1'b1;
      if (b > r.trig)  return (b - r.trig) <= SUCC_N;
      return (r.trig - b) <= PREC_N;
   endfunction

   always @(posedge clk) begin
      exp_req = cur_req;
      if (!rst_n) begin
         lst.delete();
         m_av  = 1'b0;
         m_hwe = 1'b0;
         m_act = '{0, '0, '0};
      end else begin
         m_hwe = 1'b0;
         if (ret_valid) begin
            int b;
            b = int'(ret_addr) >> LOG_BLK;
            if (!m_av) begin
               m_av  = 1'b1;
               m_act = '{b, '0, '0};
            end else if (contains(m_act, b)) begin
               if (b > m_act.trig)      m_act.sv[b - m_act.trig - 1] = 1'b1;
               else if (b < m_act.trig) m_act.pv[m_act.trig - b - 1] = 1'b1;
            end else begin
               int k;
               k = -1;
               for (int i = 0; i < lst.size(); i++)
                  if (k < 0 && contains(lst[i], b)) k = i;
               if (k >= 0) begin
                  region_t tmp;
                  tmp = lst[k];
                  lst.delete(k);
                  lst.push_front(m_act);
                  m_act = tmp;
               end else begin
                  m_hwe  = 1'b1;
                  m_hist = m_act;
                  if (lst.size() == DEPTH) void'(lst.pop_back());
                  lst.push_front(m_act);
                  m_act = '{b, '0, '0};
               end
            end
         end
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         check(exp_req, "act_valid", int'(act_valid), int'(m_av));
         check(exp_req, "hist_we", int'(hist_we), int'(m_hwe));
         if (m_av) begin
            check(exp_req, "act_trigger", int'(act_trigger), m_act.trig);
            check(exp_req, "act_prev", int'(act_prev), int'(m_act.pv));
            check(exp_req, "act_succ", int'(act_succ), int'(m_act.sv));
         end
         if (m_hwe) begin
            check(exp_req, "hist_trigger", int'(hist_trigger), m_hist.trig);
            check(exp_req, "hist_prev", int'(hist_prev), int'(m_hist.pv));
            check(exp_req, "hist_succ", int'(hist_succ), int'(m_hist.sv));
         end
      end
   end

   task automatic step(bit v, int blk, string req);
      @(negedge clk);
      cur_req   = req;
      ret_valid = v;
      ret_addr  = ADDR_W'((blk << LOG_BLK) | ($urandom % (1 << LOG_BLK)));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      checking = 1'b1;
      // R1: reset state, observed before release
      check("R1", "reset act_valid", int'(act_valid), 0);
      check("R1", "reset hist_we", int'(hist_we), 0);
      rst_n = 1'b1;
      step(0, 'h100, "R1");
      step(1, 'h100, "R2");            // first address
      step(1, 'h100, "R3");            // same block, other offset
      step(1, 'h102, "R4");            // +2 -> succ bit 1
      step(1, 'h105, "R4");            // +5 -> succ bit 4 (edge)
      step(1, 'h0FF, "R5");            // -1 -> prev bit 0
      step(1, 'h0FD, "R5");            // -3 -> prev bit 2 (edge)
      for (int i = 0; i < 3; i++) step(0, 'h700 + i * 40, "R9");
      step(1, 'h106, "R7");            // +6 -> outside, miss
      step(1, 'h0FB, "R7");            // -5 below 0x100, outside 0x106 -> miss
      step(1, 'h101, "R6");            // listed 0x100 region -> swap back
      step(1, 'h107, "R6");            // listed 0x106 region -> swap
      for (int i = 0; i < 6; i++) step(1, 'h300 + i * 'h10, "R8");
      step(1, 'h100, "R8");            // discarded earlier -> miss
      // R10: overlapping listed regions
      step(1, 'h504, "R10");
      step(1, 'h500, "R10");           // -4 -> miss
      step(1, 'h510, "R10");           // miss, list: 0x500, 0x504, ...
      step(1, 'h502, "R10");           // both listed regions match; 0x500 wins
      step(1, 'h510, "R10");
      step(1, 'h507, "R10");
      // Random stream over a narrow range
      for (int i = 0; i < 3000; i++)
         step(($urandom % 5) != 0, 'h200 + ($urandom % 48), "R6");
      step(0, 0, "R9");
      step(0, 0, "R9");
      @(negedge clk);
      finish_run();
   end
endmodule